// File: doc/BRIEF.md
# Dual-Timeslot Sync-Triggered Transmit Scheduler

This block sits in a node on a synchronous sensor bus. The controller sends a periodic sync pulse, and the node must answer at fixed delays after that pulse. A rising edge on `sync_in` restarts a 10-bit timebase. The timebase advances by one count every `PRESCALE` clocks. Two programmable slot times, A and B, are measured from that edge.

A short time before each slot start, the block captures the newest data sample into a holding register and pulses `latch_stb`. At the slot start it pulses `tx_start`, which tells a separate frame encoder to begin sending the held word. The lead time is `LAT_INTERP + DATA_SETUP` counts. The encoder returns `enc_ack` when it has taken the word. A two-bit mode input selects between double-rate operation, which sends slots A and B, and single-slot operation, which sends slot A only. In double-rate mode, a slot B that would collide with slot A is not sent.

The block is controlled by a five-state machine:

- States:
  - `S_IDLE`: waiting for a sync edge.
  - `S_A_LATCH`: waiting for A's capture point.
  - `S_A_SEND`: waiting for A's start.
  - `S_B_LATCH`: waiting for B's capture point.
  - `S_B_SEND`: waiting for B's start.
- Transitions:
  - *accept*: `S_IDLE` to `S_A_LATCH`, on a sync rising edge.
  - *capture*: `*_LATCH` to `*_SEND`.
  - *capture-and-send*: straight on from a `*_LATCH` state, when the capture point equals the start.
  - *skip*: the slot is dropped, because the previous word is still unacknowledged.
  - *after-A*: to `S_B_LATCH` when slot B is enabled, else to `S_IDLE`.
  - *finish*: from `S_B_SEND` to `S_IDLE`.
  - *terminal*: any running state to `S_IDLE` when the count ends at 1023.

Top module: `dual_slot_sched`

## Requirements
- R1: After reset, `latch_stb`, `tx_start`, `tx_slot`, `busy` and `tx_data` are all 0.
- R2: A sync rising edge seen in idle restarts the count at 0. The count advances once every `PRESCALE` clocks. A slot with time T has its one-clock `tx_start` visible `2 + T*PRESCALE` clocks after the clock in which `sync_in` was first driven high.
- R3: Each slot's `latch_stb` comes `LEAD = LAT_INTERP + DATA_SETUP` counts before that slot's start. For slot A, if the slot time is below the lead, the capture point is clamped to count 0. At the capture, `tx_data` takes the value `sample_in` had in the clock before `latch_stb` became visible. `tx_slot` is 0 for slot A and 1 for slot B.
- R4: `tx_mode = 2'b01` selects double rate, where slots A and B are both served. Every other `tx_mode` value serves slot A only.
- R5: In double-rate mode `lat_sel` has no effect. In single-slot mode, `lat_sel = 1` removes the lead, so slot A is captured at its own start.
- R6: When `init_phase` is 1 at the accepted sync edge, both slots carry `init_word` (as sampled at that edge) instead of `sample_in`.
- R7: In double-rate mode, slot B gets neither a capture nor a send when `slot_b_time <= slot_a_time` or `slot_b_time < slot_a_time + frame_len + LEAD`.
- R8: `tx_data` stays unchanged from a capture until `enc_ack`. If a slot reaches its capture point while the word is still unacknowledged, that slot is dropped completely.
- R9: A sync edge that arrives while busy is ignored. The slot times, frame length and mode are sampled at the accepted edge, so changing them during a run has no effect.
- R10: `busy` is 1 from the accepting clock edge until the final slot's send (or count 1023). A slot time of 1023 is still served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Sync pulse from bus controller |
| tx_mode | input | 2 | Transmission mode; 2'b01 selects double rate |
| lat_sel | input | 1 | Low-latency select (single-slot mode only) |
| slot_a_time | input | CNT_W | Slot A start, in counts after the sync edge |
| slot_b_time | input | CNT_W | Slot B start, in counts after the sync edge |
| frame_len | input | CNT_W | Frame duration in counts, used for conflict check |
| init_phase | input | 1 | Send the initialization word instead of samples |
| init_word | input | DATA_W | Initialization data word |
| sample_in | input | DATA_W | Newest data sample |
| enc_ack | input | 1 | Encoder has taken the held word |
| latch_stb | output | 1 | One-clock capture strobe |
| tx_start | output | 1 | One-clock transmit-start strobe |
| tx_slot | output | 1 | Slot of the held word (0 = A, 1 = B) |
| tx_data | output | DATA_W | Held data word |
| busy | output | 1 | Schedule in progress |

## Verification
The main function is swept over a grid that combines:
- slot A times below, at and above the lead;
- slot B times below, equal to and beyond slot A;
- two frame lengths;
- both mode classes;
- both latency-select values.

Capture and send clocks are compared against arithmetic from the slot values. Points on either side of the conflict boundary tell a suppressed slot B from a served one. Points where slot A is shorter than the lead tell the clamped capture point from the normal one.

Targeted runs cover the remaining cases:
- A late acknowledge shows that a dropped slot differs from a conflict.
- A second sync pulse with altered slot values during a run shows that configuration is sampled at the accepted edge.
- An initialization run shows that both slots carry the same word.
- A slot at count 1023 shows that the terminal count is still served.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_A_LATCH,
        S_A_SEND,
        S_B_LATCH,
        S_B_SEND
    } sched_state_e;

    localparam logic [1:0] MODE_DOUBLE = 2'b01;
    localparam logic       SLOT_A      = 1'b0;
    localparam logic       SLOT_B      = 1'b1;

endpackage

// File: rtl/ds_sync_edge.sv
module ds_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic rise
);
    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sync_in;
    end

    assign rise = sync_in & ~sync_q;

endmodule

// File: rtl/ds_timebase.sv
module ds_timebase #(
    parameter int CNT_W    = 10,
    parameter int PRESCALE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             fresh,
    output logic             last
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             wrap;
    logic [CNT_W-1:0] cnt_q;

    generate
        if (PRESCALE > 1) begin : g_pre
            localparam int PW = $clog2(PRESCALE);
            logic [PW-1:0] pre_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     pre_q <= '0;
                else if (start) pre_q <= '0;
                else if (run)   pre_q <= wrap ? '0 : pre_q + PW'(1);
            end

            assign fresh = (pre_q == '0);
            assign wrap  = (pre_q == PW'(PRESCALE - 1));
        end else begin : g_nopre
            assign fresh = 1'b1;
            assign wrap  = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            cnt_q <= '0;
        else if (start)                        cnt_q <= '0;
        else if (run && wrap && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
    end

    assign cnt  = cnt_q;
    assign last = run && wrap && (cnt_q == CNT_MAX);

    // R2: a sync edge restarts the timebase at count 0, first tick
    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == '0) && fresh);

    // R2: the count steps by exactly one per prescaled tick
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start && wrap && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/ds_slot_plan.sv
module ds_slot_plan #(
    parameter int CNT_W = 10,
    parameter int LEAD  = 3
) (
    input  logic [CNT_W-1:0] slot_a,
    input  logic [CNT_W-1:0] slot_b,
    input  logic [CNT_W-1:0] flen,
    input  logic             dbl,
    input  logic             lat_sel,
    output logic [CNT_W-1:0] a_lat,
    output logic [CNT_W-1:0] b_lat,
    output logic             conflict,
    output logic             b_enable
);
    localparam int EW = CNT_W + 2;

    logic [EW-1:0] a_e, b_e, f_e, lead_a, lead_b;

    always_comb begin
        a_e    = EW'(slot_a);
        b_e    = EW'(slot_b);
        f_e    = EW'(flen);
        lead_b = EW'(LEAD);
        lead_a = (dbl || !lat_sel) ? EW'(LEAD) : '0;
        a_lat  = (a_e >= lead_a) ? CNT_W'(a_e - lead_a) : '0;
        b_lat  = (b_e >= lead_b) ? CNT_W'(b_e - lead_b) : '0;
        conflict = (b_e <= a_e) || (b_e < a_e + f_e + lead_b);
        b_enable = dbl && !conflict;
    end

endmodule

// File: rtl/dual_slot_sched.sv
module dual_slot_sched
    import sched_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int DATA_W     = 16,
    parameter int PRESCALE   = 2,
    parameter int LAT_INTERP = 2,
    parameter int DATA_SETUP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_in,
    input  logic [1:0]        tx_mode,
    input  logic              lat_sel,
    input  logic [CNT_W-1:0]  slot_a_time,
    input  logic [CNT_W-1:0]  slot_b_time,
    input  logic [CNT_W-1:0]  frame_len,
    input  logic              init_phase,
    input  logic [DATA_W-1:0] init_word,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              enc_ack,
    output logic              latch_stb,
    output logic              tx_start,
    output logic              tx_slot,
    output logic [DATA_W-1:0] tx_data,
    output logic              busy
);
    localparam int LEAD = LAT_INTERP + DATA_SETUP;

    sched_state_e state_q, state_d, after_a;

    logic              sync_rise, accept;
    logic [CNT_W-1:0]  tb_cnt;
    logic              tb_fresh, tb_last;

    logic [CNT_W-1:0]  cfg_a_q, cfg_b_q, cfg_flen_q;
    logic              cfg_dbl_q, cfg_lsel_q, cfg_init_q;
    logic [DATA_W-1:0] cfg_word_q;

    logic [CNT_W-1:0]  a_lat, b_lat;
    logic              b_conflict, b_enable;

    logic              a_lat_hit, a_tx_hit, b_lat_hit, b_tx_hit;
    logic              pend_q, hold_busy;
    logic              do_latch, do_tx, ev_slot;

    ds_sync_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_in),
        .rise    (sync_rise)
    );

    assign accept = sync_rise && (state_q == S_IDLE);

    ds_timebase #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .run   (state_q != S_IDLE),
        .cnt   (tb_cnt),
        .fresh (tb_fresh),
        .last  (tb_last)
    );

    ds_slot_plan #(.CNT_W(CNT_W), .LEAD(LEAD)) u_plan (
        .slot_a   (cfg_a_q),
        .slot_b   (cfg_b_q),
        .flen     (cfg_flen_q),
        .dbl      (cfg_dbl_q),
        .lat_sel  (cfg_lsel_q),
        .a_lat    (a_lat),
        .b_lat    (b_lat),
        .conflict (b_conflict),
        .b_enable (b_enable)
    );

    // configuration snapshot at the accepted sync edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_a_q    <= '0;
            cfg_b_q    <= '0;
            cfg_flen_q <= '0;
            cfg_dbl_q  <= 1'b0;
            cfg_lsel_q <= 1'b0;
            cfg_init_q <= 1'b0;
            cfg_word_q <= '0;
        end else if (accept) begin
            cfg_a_q    <= slot_a_time;
            cfg_b_q    <= slot_b_time;
            cfg_flen_q <= frame_len;
            cfg_dbl_q  <= (tx_mode == MODE_DOUBLE);
            cfg_lsel_q <= lat_sel;
            cfg_init_q <= init_phase;
            cfg_word_q <= init_word;
        end
    end

    assign a_lat_hit = tb_fresh && (tb_cnt == a_lat);
    assign a_tx_hit  = tb_fresh && (tb_cnt == cfg_a_q);
    assign b_lat_hit = tb_fresh && (tb_cnt == b_lat);
    assign b_tx_hit  = tb_fresh && (tb_cnt == cfg_b_q);
    assign hold_busy = pend_q && !enc_ack;
    assign after_a   = b_enable ? S_B_LATCH : S_IDLE;

    // next state and event decode
    always_comb begin
        state_d  = state_q;
        do_latch = 1'b0;
        do_tx    = 1'b0;
        ev_slot  = SLOT_A;
        unique case (state_q)
            S_IDLE: begin
                if (accept) state_d = S_A_LATCH;
            end
            S_A_LATCH: begin
                if (a_lat_hit) begin
                    if (hold_busy) begin
                        state_d = after_a;
                    end else begin
                        do_latch = 1'b1;
                        if (a_tx_hit) begin
                            do_tx   = 1'b1;
                            state_d = after_a;
                        end else begin
                            state_d = S_A_SEND;
                        end
                    end
                end
            end
            S_A_SEND: begin
                if (a_tx_hit) begin
                    do_tx   = 1'b1;
                    state_d = after_a;
                end
            end
            S_B_LATCH: begin
                ev_slot = SLOT_B;
                if (b_lat_hit) begin
                    if (hold_busy) begin
                        state_d = S_IDLE;
                    end else begin
                        do_latch = 1'b1;
                        if (b_tx_hit) begin
                            do_tx   = 1'b1;
                            state_d = S_IDLE;
                        end else begin
                            state_d = S_B_SEND;
                        end
                    end
                end
            end
            S_B_SEND: begin
                ev_slot = SLOT_B;
                if (b_tx_hit) begin
                    do_tx   = 1'b1;
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
        if (state_q != S_IDLE && tb_last && state_d == state_q)
            state_d = S_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_stb <= 1'b0;
            tx_start  <= 1'b0;
            tx_slot   <= SLOT_A;
            tx_data   <= '0;
            pend_q    <= 1'b0;
        end else begin
            latch_stb <= do_latch;
            tx_start  <= do_tx;
            if (do_latch) begin
                tx_slot <= ev_slot;
                tx_data <= cfg_init_q ? cfg_word_q : sample_in;
                pend_q  <= 1'b1;
            end else if (enc_ack) begin
                pend_q  <= 1'b0;
            end
        end
    end

    assign busy = (state_q != S_IDLE);

    // R4: slot B is only ever sent in double-rate mode
    p_single_only_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && tx_slot == SLOT_B) |-> cfg_dbl_q);

    // R7: a conflicting slot B is never captured or sent
    p_conflict_no_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_start || latch_stb) && tx_slot == SLOT_B) |-> !b_conflict);

    // R8: held word is stable until the encoder acknowledges it
    p_hold_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !enc_ack) |=> $stable(tx_data));

    // R9: a run only begins on a sync rising edge
    p_start_on_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sync_rise));

endmodule

// File: tb/tb_dual_slot_sched.sv
module tb_dual_slot_sched;
    localparam int CNT_W  = 10;
    localparam int DW     = 12;
    localparam int PS     = 2;
    localparam int LEAD   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_in = 1'b0;
    logic [1:0]    tx_mode = 2'b00;
    logic          lat_sel = 1'b0;
    logic [CNT_W-1:0] slot_a_time = '0, slot_b_time = '0, frame_len = '0;
    logic          init_phase = 1'b0;
    logic [DW-1:0] init_word = '0;
    logic [DW-1:0] sample_in = '0;
    logic          enc_ack;
    logic          latch_stb, tx_start, tx_slot, busy;
    logic [DW-1:0] tx_data;

    logic ack_auto = 1'b0, ack_arm = 1'b0, ack_man = 1'b0;
    bit   auto_ack = 1'b1;
    assign enc_ack = ack_auto | ack_man;

    int cyc = 0;
    int checks = 0, failures = 0;
    bit finished = 1'b0;

    int n_lat = 0, n_tx = 0;
    int lc[8], lslot[8], ldat[8], tcy[8], tslot[8];

    always #10 clk = ~clk;

    dual_slot_sched #(
        .CNT_W(CNT_W), .DATA_W(DW), .PRESCALE(PS), .LAT_INTERP(2), .DATA_SETUP(1)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .tx_mode(tx_mode),
        .lat_sel(lat_sel), .slot_a_time(slot_a_time), .slot_b_time(slot_b_time),
        .frame_len(frame_len), .init_phase(init_phase), .init_word(init_word),
        .sample_in(sample_in), .enc_ack(enc_ack), .latch_stb(latch_stb),
        .tx_start(tx_start), .tx_slot(tx_slot), .tx_data(tx_data), .busy(busy)
    );

    function automatic int fsamp(int c);
        return (c * 37 + 5) & ((1 << DW) - 1);
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // sample source, encoder acknowledge model and event monitor
    always @(negedge clk) begin
        sample_in = DW'(fsamp(cyc));
        ack_auto  = ack_arm;
        ack_arm   = tx_start && auto_ack;
        if (latch_stb) begin
            lc[n_lat % 8]    = cyc;
            lslot[n_lat % 8] = int'(tx_slot);
            ldat[n_lat % 8]  = int'(tx_data);
            n_lat++;
        end
        if (tx_start) begin
            tcy[n_tx % 8]   = cyc;
            tslot[n_tx % 8] = int'(tx_slot);
            n_tx++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_run(input int a, input int b, input int fl, input logic [1:0] md,
                          input logic ls, input logic ini, input int iw,
                          input bit late_ack, input bit mid_sync,
                          input string cnt_tag, input string lat_tag, input string dat_tag);
        int xs, bl, bt, g, lead, alat, nexp;
        bit dbl, conf, ben;
        int el[2], es[2], et[2];
        auto_ack = !late_ack;
        @(negedge clk);
        slot_a_time = CNT_W'(a);
        slot_b_time = CNT_W'(b);
        frame_len   = CNT_W'(fl);
        tx_mode     = md;
        lat_sel     = ls;
        init_phase  = ini;
        init_word   = DW'(iw);
        sync_in     = 1'b1;
        xs = cyc; bl = n_lat; bt = n_tx;
        @(negedge clk);
        sync_in = 1'b0;
        chk("R10", "busy after accept", int'(busy), 1);
        if (mid_sync) begin
            repeat (40) @(negedge clk);
            sync_in     = 1'b1;
            slot_b_time = CNT_W'(b - 7);
            slot_a_time = CNT_W'(a + 2);
            tx_mode     = 2'b00;
            @(negedge clk);
            sync_in = 1'b0;
        end
        g = 0;
        while (busy && g < 5000) begin
            @(negedge clk);
            g++;
        end
        repeat (3) @(negedge clk);
        chk("R10", "busy after run", int'(busy), 0);
        if (late_ack) begin
            ack_man = 1'b1;
            @(negedge clk);
            ack_man = 1'b0;
            auto_ack = 1'b1;
        end
        // expected schedule
        dbl  = (md == 2'b01);
        lead = dbl ? LEAD : (ls ? 0 : LEAD);
        alat = (a >= lead) ? a - lead : 0;
        conf = (b <= a) || (b < a + fl + LEAD);
        ben  = dbl && !conf && !late_ack;
        el[0] = alat; et[0] = a; es[0] = 0;
        el[1] = b - LEAD; et[1] = b; es[1] = 1;
        nexp = ben ? 2 : 1;
        chk(cnt_tag, "capture count", n_lat - bl, nexp);
        chk(cnt_tag, "send count", n_tx - bt, nexp);
        for (int i = 0; i < nexp && i < n_lat - bl; i++) begin
            chk(lat_tag, "capture clock", lc[(bl + i) % 8], xs + 2 + el[i] * PS);
            chk("R3", "capture slot", lslot[(bl + i) % 8], es[i]);
            chk(dat_tag, "capture data", ldat[(bl + i) % 8],
                ini ? (iw & ((1 << DW) - 1)) : fsamp(lc[(bl + i) % 8] - 1));
        end
        for (int i = 0; i < nexp && i < n_tx - bt; i++) begin
            chk("R2", "send clock", tcy[(bt + i) % 8], xs + 2 + et[i] * PS);
            chk("R3", "send slot", tslot[(bt + i) % 8], es[i]);
        end
    endtask

    int a_set[5] = '{0, 1, 3, 5, 40};
    int b_set[5] = '{0, 4, 10, 30, 60};
    int f_set[2] = '{2, 8};

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "latch_stb in reset", int'(latch_stb), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "latch_stb", int'(latch_stb), 0);
        chk("R1", "tx_start", int'(tx_start), 0);
        chk("R1", "tx_slot", int'(tx_slot), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "tx_data", int'(tx_data), 0);

        for (int ia = 0; ia < 5; ia++)
            for (int ib = 0; ib < 5; ib++)
                for (int jf = 0; jf < 2; jf++)
                    for (int m = 0; m < 2; m++)
                        for (int l = 0; l < 2; l++) begin
                            automatic int a = a_set[ia];
                            automatic int b = b_set[ib];
                            automatic int f = f_set[jf];
                            automatic bit cf = (b <= a) || (b < a + f + LEAD);
                            do_run(a, b, f, m ? 2'b01 : 2'b00, l, 1'b0, 0, 1'b0, 1'b0,
                                   (m && cf) ? "R7" : "R4",
                                   (m && l) ? "R5" : ((!m && l) ? "R5" : "R3"),
                                   "R3");
                        end

        // R4: other mode code is single slot
        do_run(5, 40, 2, 2'b11, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R4", "R3", "R3");
        do_run(5, 40, 2, 2'b10, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R4", "R5", "R3");
        // R6: initialization word in both slots
        do_run(6, 25, 4, 2'b01, 1'b0, 1'b1, 12'hA5C, 1'b0, 1'b0, "R6", "R3", "R6");
        // R8: late acknowledge drops slot B
        do_run(5, 20, 2, 2'b01, 1'b0, 1'b0, 0, 1'b1, 1'b0, "R8", "R3", "R3");
        // R8: after acknowledge, both slots are served again
        do_run(5, 20, 2, 2'b01, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R8", "R3", "R3");
        // R9: sync while busy and config changes are ignored
        do_run(10, 50, 4, 2'b01, 1'b0, 1'b0, 0, 1'b0, 1'b1, "R9", "R9", "R3");
        // R10: slot at terminal count
        do_run(5, 1023, 2, 2'b01, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R10", "R10", "R3");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule